// File: doc/BRIEF.md
# Serial Register Write Slave with Address Auto-Increment

This block receives register writes over a three-wire serial control bus: a serial clock, a serial data line and an active-low select line. While select is low, the first eight bits clocked in form a register address and every following group of twenty-four bits forms a data word. Both fields arrive least-significant bit first. Each time a data word is complete, the block raises a one-cycle write strobe towards a register file, together with the address and the data.

Holding select low after the first word turns the frame into a burst. Each further complete word goes to the next higher address without a new address being sent, and the address wraps from 0xFF to 0x00. A word cut short by select rising is dropped without any write. The serial lines are brought into the system clock domain through synchronizers, and serial clock rising edges are detected there. The serial clock may therefore rest high or low between frames.

The framer runs a state machine with three states. ST_IDLE waits while select is high. Select falling moves it to ST_ADDR, which collects eight address bits. The eighth address bit moves it to ST_DATA, which collects words and stays in ST_DATA after each completed word. From either ST_ADDR or ST_DATA, select going high returns the machine to ST_IDLE, which clears the bit counter and the shift register.

Top module: `serreg_wr_slave`

## Requirements
- R1: After reset, wr_en is 0 and wr_addr and wr_data are 0.
- R2: A frame of 8 address bits followed by 24 data bits, each field least-significant bit first, produces exactly one write. Address bit 0 arrives first, and data bit 0 arrives first, right after address bit 7. The write carries that address and data.
- R3: Data is sampled only on rising edges of the serial clock. Writes come out the same whether the serial clock rests low or high between frames.
- R4: wr_en is high for exactly one system clock per completed word.
- R5: If select rises after the address and before all 24 bits of a word have arrived, that partial word produces no write. Complete words earlier in the same frame are still written.
- R6: In a burst, word k of the frame (counting from 0) is written to the start address plus k.
- R7: Incrementing the address past 0xFF wraps it to 0x00.
- R8: If select rises with fewer than 8 address bits received, no write occurs.
- R9: Select high returns the framer to the address phase. The next frame is decoded from its own first bit, however the previous frame ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| sdi | input | 1 | Serial data, least-significant bit first |
| sel_n | input | 1 | Active-low frame select |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 24 | Register data of the write |

## Verification
The bench builds the block with its default widths: an 8-bit address, 24-bit words and two synchronizer stages. These are small enough to sweep frame shapes systematically. The sweep covers both resting levels of the serial clock, start addresses at 0x00, at mid range and just below the wrap point, bursts of one to four words, and frames that end cleanly or in the middle of a word. Every truncation length of the address phase and of a first data word is also tried. Expected addresses and data are computed arithmetically from the start address and the word index.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } frm_state_t;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[s] <= RST_VAL;
            end else begin
                chain[s] <= (s == 0) ? d_in : chain[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/serreg_framer.sv
module serreg_framer
    import serreg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise,
    input  logic              sd_bit,
    input  logic              sel_hi,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frm_state_t        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg, shreg_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic              addr_done, word_done;

    assign shreg_nx  = {sd_bit, shreg[DATA_W-1:1]};
    assign addr_done = (state == ST_ADDR) && sck_rise && (bit_cnt == ADDR_LAST);
    assign word_done = (state == ST_DATA) && sck_rise && (bit_cnt == DATA_LAST);

    // Transitions: IDLE->ADDR on select low, ADDR->DATA on last address bit,
    // any active state -> IDLE on select high.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (!sel_hi)        state_nx = ST_ADDR;
            ST_ADDR: if (sel_hi)         state_nx = ST_IDLE;
                     else if (addr_done) state_nx = ST_DATA;
            ST_DATA: if (sel_hi)         state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Bit counter, shift register and running address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            cur_addr <= '0;
        end else if (sel_hi || state == ST_IDLE) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (sck_rise) begin
            shreg <= shreg_nx;
            if (addr_done) begin
                bit_cnt  <= '0;
                cur_addr <= shreg_nx[DATA_W-1 -: ADDR_W];
            end else if (word_done) begin
                bit_cnt  <= '0;
                cur_addr <= cur_addr + 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Outputs: one-cycle strobe with address and data registered together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= word_done && !sel_hi;
            if (word_done && !sel_hi) begin
                wr_addr <= cur_addr;
                wr_data <= shreg_nx;
            end
        end
    end

    // Observation registers for the burst-step property.
    logic [ADDR_W-1:0] last_addr;
    logic              have_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_addr <= '0;
            have_prev <= 1'b0;
        end else if (state == ST_IDLE) begin
            have_prev <= 1'b0;
        end else if (wr_en) begin
            last_addr <= wr_addr;
            have_prev <= 1'b1;
        end
    end

    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    a_r5_strobe_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state) == ST_DATA);
    a_r8_no_write_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |=> !wr_en);
    a_r6_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && have_prev) |-> wr_addr == ADDR_W'(last_addr + 1'b1));
    a_r9_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (bit_cnt == '0));
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= DATA_LAST);
endmodule

// File: rtl/serreg_wr_slave.sv
module serreg_wr_slave #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              sdi,
    input  logic              sel_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    logic [2:0] pins_s;
    logic       sck_d;

    serreg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sel_n, sdi, sck}),
        .d_out (pins_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= pins_s[0];
    end

    serreg_framer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_rise (pins_s[0] & ~sck_d),
        .sd_bit   (pins_s[1]),
        .sel_hi   (pins_s[2]),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );
endmodule

// File: tb/serreg_wr_slave_test.sv
module serreg_wr_slave_test;
    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, sdi = 1'b0, sel_n = 1'b1;
    logic        wr_en;
    logic [7:0]  wr_addr;
    logic [23:0] wr_data;

    int n_chk = 0, n_bad = 0;
    int rx_cnt = 0, wide_cnt = 0;
    logic [7:0]  rx_addr [64];
    logic [23:0] rx_data [64];
    logic        prev_en = 1'b0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    serreg_wr_slave uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .sel_n(sel_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_en) begin
                if (prev_en) wide_cnt++;
                if (rx_cnt < 64) begin
                    rx_addr[rx_cnt] = wr_addr;
                    rx_data[rx_cnt] = wr_data;
                end
                rx_cnt++;
            end
            prev_en = wr_en;
        end
    end

    function automatic logic [23:0] word_val(input logic [7:0] a, input int k);
        logic [23:0] v;
        v = ({16'd0, a} * 24'h010203) + (24'(k) * 24'h3C5A69);
        return v ^ 24'hA5C3E1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sck = 1'b0;
        sdi = b;
        repeat (HALF) @(posedge clk);
        sck = 1'b1;
        repeat (HALF) @(posedge clk);
    endtask

    // Send a frame: abits address bits, then nwords full words plus extra bits.
    task automatic frame(input logic [7:0] a, input int abits, input int nwords,
                         input int extra, input bit idle_hi, input string req);
        logic [23:0] w;
        int exp_n;
        rx_cnt = 0;
        wide_cnt = 0;
        sck = idle_hi;
        repeat (HALF) @(posedge clk);
        sel_n = 1'b0;
        repeat (2 * HALF) @(posedge clk);
        for (int i = 0; i < abits; i++) send_bit(a[i]);
        if (abits == 8) begin
            for (int k = 0; k < nwords; k++) begin
                w = word_val(a, k);
                for (int i = 0; i < 24; i++) send_bit(w[i]);
            end
            w = word_val(a, nwords);
            for (int i = 0; i < extra; i++) send_bit(w[i]);
        end
        if (!idle_hi) sck = 1'b0;
        repeat (HALF) @(posedge clk);
        sel_n = 1'b1;
        repeat (10) @(posedge clk);
        exp_n = (abits == 8) ? nwords : 0;
        check({req, " write count"}, 32'(rx_cnt), 32'(exp_n));
        check("R4 strobe width", 32'(wide_cnt), 32'd0);
        for (int k = 0; k < exp_n && k < 64 && k < rx_cnt; k++) begin
            check((a + 8'(k) < a) ? "R7 wrapped addr" : "R6 burst addr",
                  32'(rx_addr[k]), 32'(8'(a + 8'(k))));
            check("R2 data LSB-first", 32'(rx_data[k]), 32'(word_val(a, k)));
        end
    endtask

    initial begin
        logic [7:0] starts [4];
        starts[0] = 8'h00; starts[1] = 8'h5A; starts[2] = 8'hFE; starts[3] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset wr_en", 32'(wr_en), 32'd0);
        check("R1 reset wr_addr", 32'(wr_addr), 32'd0);
        check("R1 reset wr_data", 32'(wr_data), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        // R3 both idle levels, R6/R7 bursts, R5 trailing partial words
        for (int ih = 0; ih < 2; ih++)
            for (int s = 0; s < 4; s++)
                for (int n = 1; n <= 4; n++)
                    for (int e = 0; e < 2; e++)
                        frame(starts[s], 8, n, e * 13, ih[0],
                              e ? "R5 partial tail" : "R3 burst");
        // R8 every address truncation, each followed by a clean frame (R9)
        for (int ab = 0; ab < 8; ab++) begin
            frame(8'(8'h30 + ab), ab, 1, 0, ab[0], "R8 address cut");
            frame(8'(8'h90 + ab), 8, 1, 0, ab[0], "R9 next frame");
        end
        // R5 every truncation length of a lone first word
        for (int e = 0; e < 24; e++)
            frame(8'(8'hC0 + e), 8, 0, e, e[0], "R5 cut word");
        frame(8'h11, 8, 1, 0, 1'b0, "R9 after cut");
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule